// File: doc/BRIEF.md
# Byte-Wide Indirect Register Window

This bridge lets a host whose data path is one byte wide reach a bank of 32-bit registers. The host sees two locations. The index port at offset 0 holds an 8-bit register index. The data window at offsets 4 to 7 carries that register as four byte lanes. To reach a register, the host writes the index once and then moves the four lanes in order. The most significant byte comes first, in lane 0, at offset 4.

On the register side the bridge drives a simple single-cycle bus. It carries an index, a 32-bit write word, a write strobe, a read strobe and a read word. The register bank returns the read word combinationally in the cycle the read strobe is high.

Reads are snapshot based. Reading lane 0 fetches the whole word, and lanes 1 to 3 are served from that copy. Writes are staged. Lanes 0 to 2 fill a staging buffer, and the write to lane 3 commits all 32 bits in one strobe.

The identity register is produced inside the bridge. Indices outside the register map are never passed to the register bus.

Top module: `byte_window_bridge`

## Requirements
- R1: After synchronous reset the following outputs are low: host_rvalid, reg_we and reg_re. The index latch, reg_idx and host_rdata are zero.
- R2: A host write to offset 0 loads the index latch from host_wdata. A read of offset 0 returns the latched index. The latch changes only on a write to offset 0.
- R3: Data lanes are ordered most significant first. Offset 4 (lane 0) is bits 31:24, offset 5 is bits 23:16, offset 6 is bits 15:8 and offset 7 (lane 3) is bits 7:0.
- R4: A read of lane 0 at a forwarded index produces exactly one reg_re pulse, one cycle after the request, with reg_idx equal to the latched index. Reads of lanes 1 to 3 produce no reg_re.
- R5: A read of lane 1, 2 or 3 returns bytes of the word captured by the most recent lane-0 read, even if the register has changed since.
- R6: Writes to lanes 0 to 2 produce no reg_we. A write to lane 3 at a forwarded index produces exactly one reg_we, one cycle later, with reg_wdata equal to {lane0, lane1, lane2, lane3}.
- R7: Index 0x04 is a read-only identity word produced inside the bridge.
  - Bits 31:16 hold a vendor code, 15:12 the port count, 11:8 zero, 7:4 the implementation number and 3:0 the version. The default is 0x5C3E2013.
  - It is never forwarded. Writes to it produce no reg_we and leave the value unchanged.
- R8: Only indices 0x00, 0x08, 0x0C, 0x10 and 0x20 are forwarded. At any other index except 0x04:
  - reads return zero and produce no reg_re;
  - writes produce no reg_we.
- R9: Offsets 1 to 3 are reserved. Reads of them return zero, and writes to them change neither the index nor the register bus.
- R10: Every host read request yields exactly one host_rvalid pulse, two cycles after the request. host_rdata is valid in that cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| host_addr | input | 3 | Host byte offset: 0 index, 4..7 data lanes |
| host_wr | input | 1 | Host byte write request, one cycle |
| host_rd | input | 1 | Host byte read request, one cycle |
| host_wdata | input | 8 | Host write byte |
| host_rdata | output | 8 | Host read byte, registered |
| host_rvalid | output | 1 | host_rdata valid, two cycles after the read |
| reg_idx | output | 8 | Register bus index (latched index) |
| reg_wdata | output | 32 | Register bus write word |
| reg_we | output | 1 | Register bus write strobe |
| reg_re | output | 1 | Register bus read strobe |
| reg_rdata | input | 32 | Register bus read word, valid while reg_re is high |

## Verification
The bench sweeps all 256 indices with a distinct pattern per index, so three classes of fault show up.
- A lane swap or reversed byte order returns bytes in the wrong positions.
- A leaky map decode produces a spurious strobe or a nonzero read at an unmapped index.
- An identity register that accepts writes reads back the written pattern instead of the fixed code.

The snapshot test changes the register between lane 0 and the later lanes. A bridge that re-reads the bus on every lane then returns bytes of the new value, and the read is torn. Write strobes are counted after each lane, which catches a design that commits early or issues more than one strobe. The reserved offsets are written and the index read back, which exposes an address decode that aliases them onto the index port.

// File: rtl/bwb_pkg.sv
package bwb_pkg;

  // Register map (index values the bridge recognises)
  localparam logic [31:0] IDX_CTRL   = 32'h00;
  localparam logic [31:0] IDX_IDENT  = 32'h04;
  localparam logic [31:0] IDX_CNT0   = 32'h08;
  localparam logic [31:0] IDX_CNT1   = 32'h0C;
  localparam logic [31:0] IDX_SHADOW = 32'h10;
  localparam logic [31:0] IDX_PCTRL  = 32'h20;

  // What a host address refers to
  typedef enum logic [1:0] {
    SRC_NONE  = 2'd0,
    SRC_INDEX = 2'd1,
    SRC_LANE  = 2'd2
  } hsrc_e;

  // How an index is served
  typedef enum logic [1:0] {
    KIND_UNMAPPED = 2'd0,
    KIND_FWD      = 2'd1,
    KIND_IDENT    = 2'd2
  } rkind_e;

  function automatic rkind_e classify(input logic [31:0] idx);
    rkind_e k;
    case (idx)
      IDX_IDENT:                                         k = KIND_IDENT;
      IDX_CTRL, IDX_CNT0, IDX_CNT1, IDX_SHADOW, IDX_PCTRL: k = KIND_FWD;
      default:                                           k = KIND_UNMAPPED;
    endcase
    return k;
  endfunction

endpackage

// File: rtl/bwb_host_decode.sv
module bwb_host_decode
  import bwb_pkg::*;
#(
  parameter int HADDR_W   = 3,
  parameter int LANES     = 4,
  parameter int DATA_BASE = 4,
  localparam int LANE_W   = (LANES > 1) ? $clog2(LANES) : 1
) (
  input  logic [HADDR_W-1:0] addr_i,
  output hsrc_e              src_o,
  output logic [LANE_W-1:0]  lane_o
);

  logic [HADDR_W-1:0] offs;

  always_comb begin
    offs   = addr_i - HADDR_W'(DATA_BASE);
    src_o  = SRC_NONE;
    lane_o = '0;
    if (addr_i == '0) begin
      src_o = SRC_INDEX;
    end else if ((int'(addr_i) >= DATA_BASE) && (int'(addr_i) < DATA_BASE + LANES)) begin
      src_o  = SRC_LANE;
      lane_o = offs[LANE_W-1:0];
    end
  end

endmodule

// File: rtl/bwb_index_map.sv
module bwb_index_map
  import bwb_pkg::*;
#(
  parameter int IDX_W = 8
) (
  input  logic [IDX_W-1:0] idx_i,
  output rkind_e           kind_o
);

  always_comb kind_o = classify(32'(idx_i));

endmodule

// File: rtl/bwb_write_stage.sv
module bwb_write_stage
  import bwb_pkg::*;
#(
  parameter int DATA_W = 32,
  parameter int BYTE_W = 8,
  localparam int LANES  = DATA_W / BYTE_W,
  localparam int LANE_W = (LANES > 1) ? $clog2(LANES) : 1,
  localparam int LAST   = LANES - 1
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_lane_i,
  input  logic [LANE_W-1:0] lane_i,
  input  logic [BYTE_W-1:0] byte_i,
  input  rkind_e            kind_i,
  output logic              reg_we_o,
  output logic [DATA_W-1:0] reg_wdata_o
);

  logic [BYTE_W-1:0] stage_q [LANES-1];
  wire  [DATA_W-1:0] commit_word;

  // Lanes 0..LAST-1 collect into staging; lane 0 is the top byte
  for (genvar l = 0; l < LAST; l++) begin : g_stage
    always_ff @(posedge clk) begin
      if (rst) begin
        stage_q[l] <= '0;
      end else if (wr_lane_i && (lane_i == LANE_W'(l))) begin
        stage_q[l] <= byte_i;
      end
    end
    assign commit_word[DATA_W-1-l*BYTE_W -: BYTE_W] = stage_q[l];
  end
  assign commit_word[BYTE_W-1:0] = byte_i;

  wire last_lane_wr = wr_lane_i && (lane_i == LANE_W'(LAST));

  always_ff @(posedge clk) begin
    if (rst) begin
      reg_we_o    <= 1'b0;
      reg_wdata_o <= '0;
    end else begin
      reg_we_o <= 1'b0;
      if (last_lane_wr && (kind_i == KIND_FWD)) begin
        reg_we_o    <= 1'b1;
        reg_wdata_o <= commit_word;
      end
    end
  end

  // R6: a strobe only ever follows a write to the last lane
  p_we_after_last_lane_r6: assert property (@(posedge clk) disable iff (rst)
    reg_we_o |-> $past(wr_lane_i && (lane_i == LANE_W'(LAST))));

  // R6: staging of lane 0 only moves when lane 0 is written
  p_stage_hold_r6: assert property (@(posedge clk) disable iff (rst)
    !(wr_lane_i && (lane_i == '0)) |=> $stable(stage_q[0]));

endmodule

// File: rtl/bwb_read_path.sv
module bwb_read_path
  import bwb_pkg::*;
#(
  parameter int DATA_W = 32,
  parameter int BYTE_W = 8,
  parameter int IDX_W  = 8,
  localparam int LANES  = DATA_W / BYTE_W,
  localparam int LANE_W = (LANES > 1) ? $clog2(LANES) : 1
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              rd_i,
  input  hsrc_e             src_i,
  input  logic [LANE_W-1:0] lane_i,
  input  rkind_e            kind_i,
  input  logic [IDX_W-1:0]  idx_i,
  input  logic [DATA_W-1:0] reg_rdata_i,
  input  logic [DATA_W-1:0] id_word_i,
  output logic              reg_re_o,
  output logic [BYTE_W-1:0] host_rdata_o,
  output logic              host_rvalid_o
);

  // Stage 1: request registered, register bus read in flight
  logic              s1_valid;
  hsrc_e             s1_src;
  logic [LANE_W-1:0] s1_lane;
  rkind_e            s1_kind;
  logic [IDX_W-1:0]  s1_idx;

  always_ff @(posedge clk) begin
    if (rst) begin
      s1_valid <= 1'b0;
      s1_src   <= SRC_NONE;
      s1_lane  <= '0;
      s1_kind  <= KIND_UNMAPPED;
      s1_idx   <= '0;
      reg_re_o <= 1'b0;
    end else begin
      s1_valid <= rd_i;
      s1_src   <= src_i;
      s1_lane  <= lane_i;
      s1_kind  <= kind_i;
      s1_idx   <= idx_i;
      reg_re_o <= rd_i && (src_i == SRC_LANE) && (lane_i == '0) && (kind_i == KIND_FWD);
    end
  end

  // Word source for a lane-0 read
  logic [DATA_W-1:0] fresh_word;
  logic [DATA_W-1:0] snap_q;

  always_comb begin
    case (s1_kind)
      KIND_FWD:   fresh_word = reg_rdata_i;
      KIND_IDENT: fresh_word = id_word_i;
      default:    fresh_word = '0;
    endcase
  end

  wire [BYTE_W-1:0] fresh_b [LANES];
  wire [BYTE_W-1:0] snap_b  [LANES];
  for (genvar l = 0; l < LANES; l++) begin : g_lane
    assign fresh_b[l] = fresh_word[DATA_W-1-l*BYTE_W -: BYTE_W];
    assign snap_b[l]  = snap_q[DATA_W-1-l*BYTE_W -: BYTE_W];
  end

  wire s1_first = s1_valid && (s1_src == SRC_LANE) && (s1_lane == '0);

  logic [BYTE_W-1:0] out_byte;
  always_comb begin
    case (s1_src)
      SRC_INDEX: out_byte = BYTE_W'(s1_idx);
      SRC_LANE:  out_byte = (s1_lane == '0) ? fresh_b[0] : snap_b[s1_lane];
      default:   out_byte = '0;
    endcase
  end

  // Stage 2: response and snapshot
  always_ff @(posedge clk) begin
    if (rst) begin
      host_rvalid_o <= 1'b0;
      host_rdata_o  <= '0;
      snap_q        <= '0;
    end else begin
      host_rvalid_o <= s1_valid;
      if (s1_valid) host_rdata_o <= out_byte;
      if (s1_first) snap_q <= fresh_word;
    end
  end

  // R10: every response lies two cycles behind its request
  p_rvalid_latency_r10: assert property (@(posedge clk) disable iff (rst)
    host_rvalid_o |-> $past(rd_i, 2));

  // R4: read strobe only from a lane-0 request
  p_re_from_lane0_r4: assert property (@(posedge clk) disable iff (rst)
    reg_re_o |-> $past(rd_i && (src_i == SRC_LANE) && (lane_i == '0)));

  // R5: snapshot only changes after a lane-0 read
  p_snapshot_hold_r5: assert property (@(posedge clk) disable iff (rst)
    !s1_first |=> $stable(snap_q));

endmodule

// File: rtl/byte_window_bridge.sv
module byte_window_bridge
  import bwb_pkg::*;
#(
  parameter int          DATA_W    = 32,
  parameter int          BYTE_W    = 8,
  parameter int          IDX_W     = 8,
  parameter int          HADDR_W   = 3,
  parameter int          DATA_BASE = 4,
  parameter logic [15:0] ID_VENDOR = 16'h5C3E,
  parameter logic [3:0]  ID_PORTS  = 4'd2,
  parameter logic [3:0]  ID_IMPL   = 4'd1,
  parameter logic [3:0]  ID_VERS   = 4'd3,
  localparam int LANES  = DATA_W / BYTE_W,
  localparam int LANE_W = (LANES > 1) ? $clog2(LANES) : 1
) (
  input  logic               clk,
  input  logic               rst,
  input  logic [HADDR_W-1:0] host_addr,
  input  logic               host_wr,
  input  logic               host_rd,
  input  logic [BYTE_W-1:0]  host_wdata,
  output logic [BYTE_W-1:0]  host_rdata,
  output logic               host_rvalid,
  output logic [IDX_W-1:0]   reg_idx,
  output logic [DATA_W-1:0]  reg_wdata,
  output logic               reg_we,
  output logic               reg_re,
  input  logic [DATA_W-1:0]  reg_rdata
);

  localparam logic [31:0] ID_WORD = {ID_VENDOR, ID_PORTS, 4'h0, ID_IMPL, ID_VERS};

  hsrc_e             src;
  logic [LANE_W-1:0] lane;
  rkind_e            kind;
  logic [IDX_W-1:0]  idx_q;
  logic [DATA_W-1:0] id_word;

  assign id_word = DATA_W'(ID_WORD);

  bwb_host_decode #(
    .HADDR_W  (HADDR_W),
    .LANES    (LANES),
    .DATA_BASE(DATA_BASE)
  ) u_decode (
    .addr_i(host_addr),
    .src_o (src),
    .lane_o(lane)
  );

  // Index latch: written only through offset 0
  always_ff @(posedge clk) begin
    if (rst) begin
      idx_q <= '0;
    end else if (host_wr && (src == SRC_INDEX)) begin
      idx_q <= IDX_W'(host_wdata);
    end
  end
  assign reg_idx = idx_q;

  bwb_index_map #(.IDX_W(IDX_W)) u_map (
    .idx_i (idx_q),
    .kind_o(kind)
  );

  bwb_write_stage #(
    .DATA_W(DATA_W),
    .BYTE_W(BYTE_W)
  ) u_wr (
    .clk        (clk),
    .rst        (rst),
    .wr_lane_i  (host_wr && (src == SRC_LANE)),
    .lane_i     (lane),
    .byte_i     (host_wdata),
    .kind_i     (kind),
    .reg_we_o   (reg_we),
    .reg_wdata_o(reg_wdata)
  );

  bwb_read_path #(
    .DATA_W(DATA_W),
    .BYTE_W(BYTE_W),
    .IDX_W (IDX_W)
  ) u_rd (
    .clk          (clk),
    .rst          (rst),
    .rd_i         (host_rd && !host_wr),
    .src_i        (src),
    .lane_i       (lane),
    .kind_i       (kind),
    .idx_i        (idx_q),
    .reg_rdata_i  (reg_rdata),
    .id_word_i    (id_word),
    .reg_re_o     (reg_re),
    .host_rdata_o (host_rdata),
    .host_rvalid_o(host_rvalid)
  );

  // R1: quiet outputs in the first cycle after reset
  p_reset_idle_r1: assert property (@(posedge clk) disable iff (rst)
    $past(rst) |-> (!host_rvalid && !reg_we && !reg_re));

  // R2: the index only moves on an index-port write
  p_index_hold_r2: assert property (@(posedge clk) disable iff (rst)
    !$past(host_wr && (host_addr == '0)) |-> $stable(reg_idx));

  // R8: strobes only ever reach forwarded indices
  p_we_mapped_r8: assert property (@(posedge clk) disable iff (rst)
    reg_we |-> (classify(32'(reg_idx)) == KIND_FWD));

  p_re_mapped_r8: assert property (@(posedge clk) disable iff (rst)
    reg_re |-> (classify(32'(reg_idx)) == KIND_FWD));

endmodule

// File: tb/byte_window_bridge_tb_top.sv
`timescale 1ns/1ps
module byte_window_bridge_tb_top;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [2:0]  host_addr = '0;
  logic        host_wr = 1'b0;
  logic        host_rd = 1'b0;
  logic [7:0]  host_wdata = '0;
  logic [7:0]  host_rdata;
  logic        host_rvalid;
  logic [7:0]  reg_idx;
  logic [31:0] reg_wdata;
  logic        reg_we;
  logic        reg_re;
  logic [31:0] reg_rdata;

  always #10 clk = ~clk;  // 50 MHz

  byte_window_bridge dut_i (
    .clk(clk), .rst(rst),
    .host_addr(host_addr), .host_wr(host_wr), .host_rd(host_rd),
    .host_wdata(host_wdata), .host_rdata(host_rdata), .host_rvalid(host_rvalid),
    .reg_idx(reg_idx), .reg_wdata(reg_wdata), .reg_we(reg_we), .reg_re(reg_re),
    .reg_rdata(reg_rdata)
  );

  // Register bank model on the register bus
  logic [31:0] bank [256];
  int          we_cnt, re_cnt, rv_cnt;
  logic [31:0] last_wdata;
  logic [7:0]  last_widx;
  logic        poke = 1'b0;
  logic [7:0]  poke_idx = '0;
  logic [31:0] poke_val = '0;

  assign reg_rdata = bank[reg_idx];

  always @(posedge clk) begin
    if (rst) begin
      for (int i = 0; i < 256; i++) bank[i] <= '0;
      we_cnt <= 0; re_cnt <= 0; rv_cnt <= 0;
      last_wdata <= '0; last_widx <= '0;
    end else begin
      if (reg_we) begin
        bank[reg_idx] <= reg_wdata;
        we_cnt        <= we_cnt + 1;
        last_wdata    <= reg_wdata;
        last_widx     <= reg_idx;
      end
      if (reg_re) re_cnt <= re_cnt + 1;
      if (host_rvalid) rv_cnt <= rv_cnt + 1;
      if (poke) bank[poke_idx] <= poke_val;
    end
  end

  localparam logic [31:0] EXP_ID = 32'h5C3E_2013;

  int   checks = 0;
  int   errors = 0;
  int   nreads = 0;
  logic done = 1'b0;
  logic wd_fail = 1'b0;

  task automatic chk(input string req, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  task automatic hwrite(input logic [2:0] a, input logic [7:0] d);
    @(negedge clk);
    host_addr = a; host_wdata = d; host_wr = 1'b1;
    @(negedge clk);
    host_wr = 1'b0;
    @(negedge clk);
  endtask

  task automatic hread(input logic [2:0] a, output logic [7:0] d);
    @(negedge clk);
    host_addr = a; host_rd = 1'b1;
    @(negedge clk);
    host_rd = 1'b0;
    chk("R10", "rvalid early", 32'(host_rvalid), 32'd0);
    @(negedge clk);
    chk("R10", "rvalid at latency 2", 32'(host_rvalid), 32'd1);
    d = host_rdata;
    nreads++;
  endtask

  // 0 unmapped, 1 forwarded, 2 identity
  function automatic int tb_kind(input int idx);
    if (idx == 'h04) return 2;
    if (idx == 'h00 || idx == 'h08 || idx == 'h0C || idx == 'h10 || idx == 'h20) return 1;
    return 0;
  endfunction

  initial begin
    logic [7:0]  b;
    logic [31:0] pat, word, exp;
    int          w0, r0, k;

    repeat (3) @(negedge clk);
    // R1 reset state
    chk("R1", "rvalid in reset", 32'(host_rvalid), 32'd0);
    chk("R1", "reg_we in reset", 32'(reg_we), 32'd0);
    chk("R1", "reg_re in reset", 32'(reg_re), 32'd0);
    chk("R1", "reg_idx in reset", 32'(reg_idx), 32'd0);
    chk("R1", "host_rdata in reset", 32'(host_rdata), 32'd0);
    rst = 1'b0;
    hread(3'd0, b);
    chk("R1", "index after reset", 32'(b), 32'd0);

    // Sweep every index: write a distinct pattern, read it back
    for (int idx = 0; idx < 256; idx++) begin
      k = tb_kind(idx);
      hwrite(3'd0, 8'(idx));
      hread(3'd0, b);
      chk("R2", "index readback", 32'(b), 32'(idx));
      pat = {8'(idx) ^ 8'hA5, 8'(idx + 'h11), ~8'(idx), 8'(idx * 3)};
      w0 = we_cnt;
      for (int l = 0; l < 3; l++) hwrite(3'(4 + l), pat[31 - 8*l -: 8]);
      chk("R6", "no strobe before last lane", 32'(we_cnt), 32'(w0));
      hwrite(3'd7, pat[7:0]);
      if (k == 1) begin
        chk("R6", "one strobe on last lane", 32'(we_cnt), 32'(w0 + 1));
        chk("R6", "committed word", last_wdata, pat);
        chk("R6", "committed index", 32'(last_widx), 32'(idx));
      end else if (k == 2) begin
        chk("R7", "identity write ignored", 32'(we_cnt), 32'(w0));
      end else begin
        chk("R8", "unmapped write ignored", 32'(we_cnt), 32'(w0));
      end
      r0 = re_cnt;
      word = '0;
      for (int l = 0; l < 4; l++) begin
        hread(3'(4 + l), b);
        word = {word[23:0], b};
      end
      exp = (k == 1) ? pat : (k == 2) ? EXP_ID : 32'h0;
      if (k == 1)      chk("R3", "lane order readback", word, exp);
      else if (k == 2) chk("R7", "identity readback", word, exp);
      else             chk("R8", "unmapped reads zero", word, exp);
      chk("R4", "read strobe count", 32'(re_cnt), 32'(r0 + ((k == 1) ? 1 : 0)));
    end

    // R5: snapshot holds while the register changes underneath
    hwrite(3'd0, 8'h0C);
    hwrite(3'd4, 8'h11); hwrite(3'd5, 8'h22); hwrite(3'd6, 8'h33); hwrite(3'd7, 8'h44);
    hread(3'd4, b);
    chk("R5", "lane0 of first value", 32'(b), 32'h11);
    @(negedge clk);
    poke_idx = 8'h0C; poke_val = 32'hAABB_CCDD; poke = 1'b1;
    @(negedge clk);
    poke = 1'b0;
    hread(3'd5, b); chk("R5", "lane1 from snapshot", 32'(b), 32'h22);
    hread(3'd6, b); chk("R5", "lane2 from snapshot", 32'(b), 32'h33);
    hread(3'd7, b); chk("R5", "lane3 from snapshot", 32'(b), 32'h44);
    hread(3'd4, b); chk("R5", "lane0 refetch", 32'(b), 32'hAA);
    hread(3'd7, b); chk("R5", "lane3 after refetch", 32'(b), 32'hDD);

    // R9: reserved offsets
    w0 = we_cnt;
    hwrite(3'd1, 8'h55); hwrite(3'd2, 8'h66); hwrite(3'd3, 8'h77);
    hread(3'd0, b); chk("R9", "index unchanged by reserved writes", 32'(b), 32'h0C);
    chk("R9", "no strobe from reserved writes", 32'(we_cnt), 32'(w0));
    for (int a = 1; a < 4; a++) begin
      hread(3'(a), b);
      chk("R9", "reserved reads zero", 32'(b), 32'h0);
    end

    // R10: one response per request
    repeat (3) @(negedge clk);
    chk("R10", "response count", 32'(rv_cnt), 32'(nreads));
    done = 1'b1;
  end

  initial begin
    int cyc = 0;
    while (!done && cyc < 100000) begin
      @(posedge clk);
      cyc++;
    end
    if (!done) begin
      wd_fail = 1'b1;
      $display("FAIL R10 watchdog actual=running expected=finished");
    end
    $display("CHECKS %0d ERRORS %0d", checks + (wd_fail ? 1 : 0), errors + (wd_fail ? 1 : 0));
    $finish;
  end

endmodule